// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (Two-Wire Block Transfers)

This block is a two-wire serial slave (I2C, standard mode) that keeps seven 8-bit configuration registers for a clock generator and shows all of them at once on a parallel output bus. A system clock that runs much faster than the serial clock samples SCL and SDA. The slave drives SDA only as an open-drain pull-down enable. The block does not stretch the clock.

A bus master changes the configuration in block transfers only. A write carries two leading bytes with no meaning, then a run of data bytes that fill the registers from register 0 upward. The master may end a write with STOP after any whole byte. A read always opens with a byte count, then gives the registers in ascending order. No register index is sent in either direction.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, registers 0..6 hold 0x01, 0xFA, 0x7E, 0xFF, 0xEF, 0xF5, 0x2B (register k in bits 8k+7..8k of `cfg_o`), and `sda_oe_o` is 0.
- R2: The slave acknowledges (pulls SDA low in the ninth bit) only the address bytes 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and it ignores every bit that follows until the next START.
- R3: In a write, the slave acknowledges the first two bytes after the address whatever their values, and neither byte changes any register.
- R4: In a write, data bytes from the third byte on go to registers 0, 1, 2 … in that order. Each data byte is acknowledged. The register takes its new value three system clocks after the rising SCL edge of the byte's last bit.
- R5: A STOP after any complete data byte leaves the registers already written with their new values and all others unchanged. A byte cut short by STOP changes nothing.
- R6: In a write, data bytes after the seventh are acknowledged and change no register.
- R7: In a read, the slave sends the byte count 7 first and then registers 0 to 6, most significant bit first.
- R8: If the master does not acknowledge a read byte, the slave releases SDA and does not drive it again until a START. A repeated START then begins a new transfer normally.
- R9: Read bytes requested after register 6 come back as 0xFF, because the slave leaves SDA released.
- R10: The slave changes its SDA drive only while the synchronised SCL is low, so SDA stays stable through each SCL high phase.
- R11: After a STOP the slave does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release it |
| cfg_o | output | 56 | Register contents, register k in bits 8k+7..8k |

## Verification
A behavioural model follows the register contents. It is compared with `cfg_o` on every system clock, so a write that lands on the wrong register, in the wrong cycle, or from one of the two leading bytes shows up at once. The stimulus includes:
- foreign and near-miss addresses, which separate address decoding from acknowledgement;
- a full seven-byte write followed by a read of all registers, which checks ordering in both directions;
- a write cut short by STOP after two bytes and three loose bits, which separates whole-byte commits from partial shifts;
- an over-long write with a false byte count, which shows that the count is ignored and extra bytes are discarded;
- reads ended early by a master NACK and then a repeated START, and reads carried past the last register, which separate bus release from continued driving.

SDA is also checked for stability across every SCL high phase in which the slave transmits.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  // Transfer phase of the serial controller
  typedef enum logic [2:0] {
    PH_IDLE,      // ignoring the bus until START
    PH_RX,        // shifting in a byte on SCL rising edges
    PH_ACK_WAIT,  // byte taken, wait for SCL low to pull SDA
    PH_ACK_DRV,   // holding the acknowledge bit
    PH_TX,        // shifting out a byte
    PH_TX_ACK,    // sampling the master's acknowledge
    PH_TX_NEXT    // acknowledged, load next byte on SCL low
  } phase_e;

  localparam logic [7:0] RELEASED_BYTE = 8'hFF;

endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_pipe_q;
  logic [LAST:0] sda_pipe_q;
  logic          scl_prev;
  logic          sda_prev;

  // idle bus level is high, so the pipes reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[LAST-1:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[LAST-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_pipe_q[LAST-1];
  assign sda_lvl  = sda_pipe_q[LAST-1];
  assign scl_prev = scl_pipe_q[LAST];
  assign sda_prev = sda_pipe_q[LAST];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank #(
  parameter int                  NREG     = 7,
  parameter int                  IDX_W    = 4,
  parameter logic [NREG*8-1:0]   DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] cfg_o
);

  logic [7:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= DEFAULTS[g*8 +: 8];
      else if (hit) regs_q[g] <= wr_data;
    end

    assign cfg_o[g*8 +: 8] = regs_q[g];
  end

  // out-of-range reads see a released line
  always_comb begin
    rd_data = clkcfg_pkg::RELEASED_BYTE;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = regs_q[k];
    end
  end

endmodule

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_pkg::*;
#(
  parameter int          NREG     = 7,
  parameter int          IDX_W    = 4,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);

  localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(2);          // first data byte
  localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(NREG + 2);   // past last register
  localparam logic [7:0]       COUNT_VAL = 8'(NREG);

  phase_e           phase_q,  phase_d;
  logic [3:0]       bits_q,   bits_d;
  logic [7:0]       shreg_q,  shreg_d;
  logic             is_adr_q, is_adr_d;
  logic             rdm_q,    rdm_d;
  logic [IDX_W-1:0] idx_q,    idx_d;
  logic             oe_q,     oe_d;

  logic [7:0]       byte_in;
  logic [7:0]       tx_byte;
  logic [IDX_W-1:0] idx_inc;

  assign byte_in = {shreg_q[6:0], sda_lvl};
  assign idx_inc = (idx_q == IDX_END) ? idx_q : idx_q + IDX_ONE;
  assign rd_idx  = idx_q - IDX_ONE;
  assign tx_byte = (idx_q == '0) ? COUNT_VAL : rd_data;
  assign wr_idx  = idx_q - IDX_FIRST;
  assign wr_data = byte_in;
  assign sda_oe  = oe_q;

  always_comb begin
    phase_d  = phase_q;
    bits_d   = bits_q;
    shreg_d  = shreg_q;
    is_adr_d = is_adr_q;
    rdm_d    = rdm_q;
    idx_d    = idx_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;

    if (start_det) begin
      phase_d  = PH_RX;
      bits_d   = '0;
      is_adr_d = 1'b1;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: ;
        PH_RX: begin
          if (scl_rise) begin
            shreg_d = byte_in;
            bits_d  = bits_q + 4'd1;
            if (bits_q == 4'd7) begin
              bits_d = '0;
              if (is_adr_q) begin
                if (byte_in[7:1] == DEV_ADDR) begin
                  phase_d  = PH_ACK_WAIT;
                  rdm_d    = byte_in[0];
                  idx_d    = '0;
                  is_adr_d = 1'b0;
                end else begin
                  phase_d = PH_IDLE;
                end
              end else begin
                phase_d = PH_ACK_WAIT;
                wr_en   = (idx_q >= IDX_FIRST) && (idx_q < IDX_END);
                idx_d   = idx_inc;
              end
            end
          end
        end
        PH_ACK_WAIT: begin
          if (scl_fall) begin
            oe_d    = 1'b1;
            phase_d = PH_ACK_DRV;
          end
        end
        PH_ACK_DRV: begin
          if (scl_fall) begin
            if (rdm_q) begin
              shreg_d = tx_byte;
              oe_d    = ~tx_byte[7];
              bits_d  = '0;
              idx_d   = idx_inc;
              phase_d = PH_TX;
            end else begin
              oe_d    = 1'b0;
              phase_d = PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) bits_d = bits_q + 4'd1;
          if (scl_fall) begin
            if (bits_q == 4'd8) begin
              oe_d    = 1'b0;
              phase_d = PH_TX_ACK;
            end else begin
              shreg_d = {shreg_q[6:0], 1'b0};
              oe_d    = ~shreg_q[6];
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) phase_d = sda_lvl ? PH_IDLE : PH_TX_NEXT;
        end
        PH_TX_NEXT: begin
          if (scl_fall) begin
            shreg_d = tx_byte;
            oe_d    = ~tx_byte[7];
            bits_d  = '0;
            idx_d   = idx_inc;
            phase_d = PH_TX;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bits_q   <= '0;
      shreg_q  <= '0;
      is_adr_q <= 1'b0;
      rdm_q    <= 1'b0;
      idx_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bits_q   <= bits_d;
      shreg_q  <= shreg_d;
      is_adr_q <= is_adr_d;
      rdm_q    <= rdm_d;
      idx_q    <= idx_d;
      oe_q     <= oe_d;
    end
  end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int                NREG        = 7,
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] CFG_RESET   = 56'h2BF5EFFF7EFA01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_o
);

  localparam int IDX_W = $clog2(NREG + 3);

  logic             rst_sync_n;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  clkcfg_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  clkcfg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkcfg_i2c_ctrl #(.NREG(NREG), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  clkcfg_reg_bank #(.NREG(NREG), .IDX_W(IDX_W), .DEFAULTS(CFG_RESET)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .cfg_o   (cfg_o)
  );

endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk #(
  parameter int NREG  = 7,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [NREG*8-1:0] cfg
);

  // R10
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .scl_lvl  (scl_lvl),
  .stop_det (stop_det),
  .sda_oe   (sda_oe_o),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .cfg      (cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb_top.sv
module clkcfg_i2c_slave_tb_top;

  localparam int H = 12;  // SCL half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [55:0] cfg_o;
  wire         sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  logic [7:0] model [7];
  logic [7:0] defaults [7] = '{8'h01, 8'hFA, 8'h7E, 8'hFF, 8'hEF, 8'hF5, 8'h2B};

  always #2 clk = ~clk;

  clkcfg_i2c_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .cfg_o    (cfg_o)
  );

  function automatic logic [55:0] model_flat();
    logic [55:0] f;
    for (int k = 0; k < 7; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // registers compared with the model on every clock (R4, R5, R3, R6)
  always @(posedge clk) begin
    #1;
    if (cmp_on) chk(cfg_o === model_flat(), "R4/R5 cfg_o per-clock", cfg_o, model_flat());
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(H/2);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H);
    scl_m = 1'b0; hold(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(H/2);
    scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  // one SCL period; upd >= 0 commits val to model[upd] when the DUT should
  task automatic mbit(input logic drv, input int upd, input logic [7:0] val,
                      output logic seen, output logic steady);
    logic s0;
    sda_m = drv; hold(H/2);
    scl_m = 1'b1;
    if (upd >= 0) begin
      repeat (3) @(posedge clk);
      model[upd] = val;
    end
    hold(H/2);
    s0 = sda_bus; seen = s0;
    hold(H/2);
    steady = (sda_bus == s0);
    scl_m = 1'b0; hold(H/2);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int upd, output bit acked);
    logic s, st;
    for (int i = 7; i >= 0; i--) mbit(b[i], (i == 0) ? upd : -1, b, s, st);
    mbit(1'b1, -1, 8'h00, s, st);
    acked = !s;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    logic s, st;
    for (int i = 7; i >= 0; i--) begin
      mbit(1'b1, -1, 8'h00, s, st);
      b[i] = s;
      chk(st, "R10 SDA stable while SCL high", 0, 1);
    end
    mbit(!mack, -1, 8'h00, s, st);
  endtask

  task automatic expect_ack(input logic [7:0] b, input int upd, input bit exp, input string req);
    bit a;
    wr_byte(b, upd, a);
    chk(a == exp, req, a, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic [7:0] wdat [7] = '{8'h11, 8'h92, 8'h33, 8'hC4, 8'h05, 8'hA6, 8'h77};
    for (int k = 0; k < 7; k++) model[k] = defaults[k];
    hold(5);
    rst_n = 1'b1;
    hold(5);
    // R1 reset state
    chk(cfg_o === model_flat(), "R1 reset cfg_o", cfg_o, model_flat());
    chk(sda_oe === 1'b0, "R1 reset sda_oe", sda_oe, 0);
    cmp_on = 1'b1;

    // R2 foreign and near-miss addresses, following byte ignored
    bus_start();
    expect_ack(8'hA0, -1, 1'b0, "R2 foreign address not acked");
    expect_ack(8'h00, -1, 1'b0, "R2 byte after foreign address ignored");
    bus_stop();
    bus_start();
    expect_ack(8'hD6, -1, 1'b0, "R2 near-miss address not acked");
    bus_stop();
    chk(sda_oe === 1'b0, "R11 released after STOP", sda_oe, 0);

    // R3 R4 full write
    bus_start();
    expect_ack(8'hD2, -1, 1'b1, "R2 write address acked");
    expect_ack(8'h3C, -1, 1'b1, "R3 command byte acked");
    expect_ack(8'h07, -1, 1'b1, "R3 count byte acked");
    for (int k = 0; k < 7; k++) expect_ack(wdat[k], k, 1'b1, "R4 data byte acked");
    bus_stop();

    // R7 read everything back
    bus_start();
    expect_ack(8'hD3, -1, 1'b1, "R2 read address acked");
    rd_byte(1'b1, rb); chk(rb == 8'd7, "R7 byte count", rb, 7);
    for (int k = 0; k < 7; k++) begin
      rd_byte(k != 6, rb); chk(rb == model[k], "R7 register readback", rb, model[k]);
    end
    bus_stop();
    chk(sda_oe === 1'b0, "R11 released after read STOP", sda_oe, 0);

    // R5 partial write ended by STOP in the middle of a byte
    bus_start();
    expect_ack(8'hD2, -1, 1'b1, "R2 write address acked");
    expect_ack(8'hFF, -1, 1'b1, "R3 command byte acked");
    expect_ack(8'h00, -1, 1'b1, "R3 count byte acked");
    expect_ack(8'h5A, 0, 1'b1, "R5 partial write byte 0");
    expect_ack(8'hE1, 1, 1'b1, "R5 partial write byte 1");
    begin
      logic s, st;
      for (int i = 0; i < 3; i++) mbit(1'b0, -1, 8'h00, s, st);
    end
    bus_stop();
    bus_start();
    expect_ack(8'hD3, -1, 1'b1, "R2 read address acked");
    rd_byte(1'b1, rb); chk(rb == 8'd7, "R7 byte count", rb, 7);
    for (int k = 0; k < 7; k++) begin
      rd_byte(k != 6, rb); chk(rb == model[k], "R5 readback after partial write", rb, model[k]);
    end
    bus_stop();

    // R6 over-long write with a false count
    bus_start();
    expect_ack(8'hD2, -1, 1'b1, "R2 write address acked");
    expect_ack(8'h81, -1, 1'b1, "R3 command byte acked");
    expect_ack(8'h01, -1, 1'b1, "R3 false count acked");
    for (int k = 0; k < 9; k++)
      expect_ack(8'(8'h20 + k * 8'h13), (k < 7) ? k : -1, 1'b1, "R6 data byte acked");
    bus_stop();

    // R8 early NACK, released bus, repeated START
    bus_start();
    expect_ack(8'hD3, -1, 1'b1, "R2 read address acked");
    rd_byte(1'b1, rb); chk(rb == 8'd7, "R7 byte count", rb, 7);
    rd_byte(1'b0, rb); chk(rb == model[0], "R8 register 0 before NACK", rb, model[0]);
    rd_byte(1'b0, rb); chk(rb == 8'hFF, "R8 slave released after NACK", rb, 8'hFF);
    bus_start();
    expect_ack(8'hD3, -1, 1'b1, "R8 repeated START address acked");
    rd_byte(1'b1, rb); chk(rb == 8'd7, "R8 count after repeated START", rb, 7);
    rd_byte(1'b0, rb); chk(rb == model[0], "R8 register 0 after repeated START", rb, model[0]);
    bus_stop();

    // R9 read past the last register
    bus_start();
    expect_ack(8'hD3, -1, 1'b1, "R2 read address acked");
    rd_byte(1'b1, rb); chk(rb == 8'd7, "R7 byte count", rb, 7);
    for (int k = 0; k < 7; k++) begin
      rd_byte(1'b1, rb); chk(rb == model[k], "R6 readback after overflow", rb, model[k]);
    end
    rd_byte(1'b1, rb); chk(rb == 8'hFF, "R9 byte past end", rb, 8'hFF);
    rd_byte(1'b0, rb); chk(rb == 8'hFF, "R9 second byte past end", rb, 8'hFF);
    bus_stop();
    chk(sda_oe === 1'b0, "R11 released at end", sda_oe, 0);

    hold(4);
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule